// File: doc/BRIEF.md
# Multiplexed Row/Column Memory Controller

This controller accepts a flat word address together with a read or write request and drives a memory whose address port is only half as wide as its internal address. Each access is sent in two strobed phases over one shared port. The upper half of the in-bank address goes out first with the row strobe of the selected bank. The lower half follows with the column strobe. A data transfer cycle then completes the access.

The memory has two banks, and each bank has its own row strobe. The most significant bit of the word address picks which of the two row strobes falls. The column strobe, the write enable and the data lines are shared by both banks.

After the data cycle the controller releases every strobe in the same cycle and holds them high for a parameterised precharge time. Only then does it accept the next request. Read data is registered inside the block and stays stable until the next read.

Top module: `mux_addr_ctrl`

## Requirements
- R1: Reset state:
  - `req_ready` is 1.
  - Both `row_stb_n` bits and `col_stb_n` are 1.
  - `mem_wr_en` is 0.
  - `done` is 0.
  - `rd_data` is 0.
- R2: Address bit 22 selects the bank. Bank b drives `row_stb_n[b]` low. At most one row strobe is low in any cycle.
- R3: Row phase:
  - A request is accepted at a clock edge while `req_ready` is 1 and `req_valid` is 1.
  - In the next cycle `mem_addr` equals `req_addr[21:11]`.
  - The selected row strobe is low, and `col_stb_n` is 1.
- R4: Column phase:
  - In the cycle after the row phase, `mem_addr` equals `req_addr[10:0]` and `col_stb_n` is 0.
  - The row strobe stays low.
  - The column strobe never falls unless a row strobe was already low in the previous cycle.
- R5: Data phase: the cycle after the column phase keeps both strobes low and `mem_addr` at the column value.
- R6: Write enable:
  - For a write (`req_write`=1), `mem_wr_en` is 1 in exactly the column and data cycles.
  - `mem_wdata` equals the request's data in those cycles.
  - For a read, `mem_wr_en` stays 0.
- R7: Read data:
  - For a read, `mem_rdata` is sampled at the end of the data cycle.
  - From the next cycle on, that value appears on `rd_data` and holds through later writes until the next read.
- R8: Done pulse: `done` is 1 for exactly one cycle, the first cycle after the data cycle.
- R9: Precharge:
  - In the cycle after the data cycle, every row strobe and the column strobe are 1 together, and `mem_wr_en` is 0.
  - They stay so for PRE_CYC cycles (default 2), after which `req_ready` returns to 1.
- R10: While `req_ready` is 0, `req_valid`, `req_addr`, `req_write` and `req_wdata` are ignored. The access in flight continues with its captured values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address: bank bit, row half, column half |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Last read word |
| mem_addr | output | 11 | Shared row/column address port |
| row_stb_n | output | 2 | Active-low row strobe, one per bank |
| col_stb_n | output | 1 | Active-low column strobe |
| mem_wr_en | output | 1 | Write enable to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory |

## Verification
The assertions assume that reset is applied before the first request. They place no condition on the request inputs while the block is busy, because those inputs have no effect during that time.

The stimulus keeps `req_valid` high with fresh random addresses and data throughout each busy period. This exercises the ignore rule. It also changes `mem_rdata` after the data cycle, so a late sample would be caught.

Random accesses cover both banks and both directions. Directed accesses cover all-zero and all-one addresses and a write that follows a read.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_DATA = 3'd3,
        ST_PRE  = 3'd4
    } mac_state_e;
endpackage

// File: rtl/mac_addr_split.sv
module mac_addr_split #(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 11,
    parameter int BANK_W = 1,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // Bank bits on top, then row half, then column half.
    assign bank = addr[ADDR_W-1 -: BANK_W];
    assign row  = addr[COL_W +: ROW_W];
    assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/mac_strobe_decode.sv
module mac_strobe_decode #(
    parameter int BANKS = 2,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [BANK_W-1:0] bank,
    input  logic              en,
    output logic [BANKS-1:0]  stb_n
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign stb_n[b] = !(en && (bank == BANK_W'(b)));
    end
endmodule

// File: rtl/mac_addr_mux.sv
module mac_addr_mux #(
    parameter int ROW_W = 11,
    parameter int COL_W = 11,
    localparam int PORT_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic              sel_col,
    output logic [PORT_W-1:0] port
);
    always_comb begin
        if (sel_col) port = PORT_W'(col);
        else         port = PORT_W'(row);
    end
endmodule

// File: rtl/mux_addr_ctrl.sv
module mux_addr_ctrl
    import mac_pkg::*;
#(
    parameter int ROW_W   = 11,
    parameter int COL_W   = 11,
    parameter int BANKS   = 2,
    parameter int DATA_W  = 32,
    parameter int PRE_CYC = 2,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int PORT_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [PORT_W-1:0] mem_addr,
    output logic [BANKS-1:0]  row_stb_n,
    output logic              col_stb_n,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int PRE_W = $clog2(PRE_CYC + 1);

    typedef struct packed {
        mac_state_e        st;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic [PRE_W-1:0]  pre_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;

    mac_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_split (
        .addr (req_addr),
        .bank (in_bank),
        .row  (in_row),
        .col  (in_col)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_ROW;
                    ctl_d.bank  = in_bank;
                    ctl_d.row   = in_row;
                    ctl_d.col   = in_col;
                    ctl_d.wr    = req_write;
                    ctl_d.wdata = req_wdata;
                end
            end
            ST_ROW:  ctl_d.st = ST_COL;
            ST_COL:  ctl_d.st = ST_DATA;
            ST_DATA: begin
                if (!ctl_q.wr) ctl_d.rdata = mem_rdata;
                ctl_d.done    = 1'b1;
                ctl_d.st      = ST_PRE;
                ctl_d.pre_cnt = PRE_W'(PRE_CYC - 1);
            end
            ST_PRE: begin
                if (ctl_q.pre_cnt == '0) ctl_d.st = ST_IDLE;
                else                     ctl_d.pre_cnt = ctl_q.pre_cnt - PRE_W'(1);
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic row_phase_on, col_phase_on;
    assign row_phase_on = (ctl_q.st == ST_ROW) || (ctl_q.st == ST_COL) || (ctl_q.st == ST_DATA);
    assign col_phase_on = (ctl_q.st == ST_COL) || (ctl_q.st == ST_DATA);

    mac_strobe_decode #(.BANKS(BANKS)) u_dec (
        .bank  (ctl_q.bank),
        .en    (row_phase_on),
        .stb_n (row_stb_n)
    );

    mac_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
        .row     (ctl_q.row),
        .col     (ctl_q.col),
        .sel_col (ctl_q.st != ST_ROW),
        .port    (mem_addr)
    );

    assign col_stb_n = !col_phase_on;
    assign mem_wr_en = ctl_q.wr && col_phase_on;
    assign mem_wdata = ctl_q.wdata;
    assign req_ready = (ctl_q.st == ST_IDLE);
    assign done      = ctl_q.done;
    assign rd_data   = ctl_q.rdata;
endmodule

// File: rtl/mac_ctrl_checker.sv
module mac_ctrl_checker #(
    parameter int BANKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BANKS-1:0] row_stb_n,
    input logic             col_stb_n,
    input logic             mem_wr_en,
    input logic             done,
    input logic             req_ready
);
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_stb_n) <= 1); // R2

    AST_COL_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_stb_n) |-> $past(~&row_stb_n)); // R4

    AST_ROW_HELD_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
        !col_stb_n |-> !(&row_stb_n)); // R5

    AST_WE_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !col_stb_n); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_stb_n) |-> (&row_stb_n && !mem_wr_en)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&row_stb_n && col_stb_n)); // R10
endmodule

bind mux_addr_ctrl mac_ctrl_checker #(.BANKS(BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_stb_n (row_stb_n),
    .col_stb_n (col_stb_n),
    .mem_wr_en (mem_wr_en),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/mux_addr_ctrl_test.sv
module mux_addr_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [31:0] rd_data;
    logic [10:0] mem_addr;
    logic [1:0]  row_stb_n;
    logic        col_stb_n;
    logic        mem_wr_en;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [31:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_addr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .row_stb_n(row_stb_n),
        .col_stb_n(col_stb_n), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [10:0] exp_row(input logic [22:0] a);
        return a[21:11];
    endfunction
    function automatic logic [10:0] exp_col(input logic [22:0] a);
        return a[10:0];
    endfunction
    function automatic logic [1:0] exp_rstb(input logic [22:0] a);
        return a[22] ? 2'b01 : 2'b10;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic junk_inputs();
        req_valid = 1'b1;
        req_addr  = 23'($urandom);
        req_write = 1'($urandom);
        req_wdata = $urandom;
    endtask

    // Called at a negedge with the controller idle.
    task automatic access(input logic [22:0] a, input bit wr, input logic [31:0] wd, input logic [31:0] rv);
        chk(req_ready == 1'b1, "R9 ready before access", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; mem_rdata = rv;
        @(negedge clk); // row phase
        junk_inputs(); // R10: busy, must be ignored
        chk(mem_addr == exp_row(a), "R3 row addr", 64'(mem_addr), 64'(exp_row(a)));
        chk(row_stb_n == exp_rstb(a), "R2 bank strobe", 64'(row_stb_n), 64'(exp_rstb(a)));
        chk(col_stb_n == 1'b1 && mem_wr_en == 1'b0, "R3 col high in row",
            64'({col_stb_n, mem_wr_en}), 64'b10);
        @(negedge clk); // column phase
        junk_inputs();
        chk(mem_addr == exp_col(a), "R4 col addr (R10 ignores busy req)", 64'(mem_addr), 64'(exp_col(a)));
        chk(col_stb_n == 1'b0 && row_stb_n == exp_rstb(a), "R4 strobes in col",
            64'({row_stb_n, col_stb_n}), 64'({exp_rstb(a), 1'b0}));
        chk(mem_wr_en == wr, "R6 we in col", 64'(mem_wr_en), 64'(wr));
        if (wr) chk(mem_wdata == wd, "R6 wdata", 64'(mem_wdata), 64'(wd));
        @(negedge clk); // data phase
        junk_inputs();
        chk(col_stb_n == 1'b0 && row_stb_n == exp_rstb(a) && mem_addr == exp_col(a),
            "R5 data phase", 64'({row_stb_n, col_stb_n, mem_addr}), 64'({exp_rstb(a), 1'b0, exp_col(a)}));
        chk(mem_wr_en == wr && done == 1'b0, "R6 we in data", 64'({mem_wr_en, done}), 64'({wr, 1'b0}));
        @(negedge clk); // precharge 1
        junk_inputs();
        mem_rdata = ~rv; // late change must not be captured
        if (!wr) last_rd = rv;
        chk(done == 1'b1, "R8 done pulse", 64'(done), 64'd1);
        chk(row_stb_n == 2'b11 && col_stb_n == 1'b1 && mem_wr_en == 1'b0, "R9 release together",
            64'({row_stb_n, col_stb_n, mem_wr_en}), 64'b1110);
        chk(rd_data == last_rd, "R7 read data", 64'(rd_data), 64'(last_rd));
        chk(req_ready == 1'b0, "R9 not ready in precharge", 64'(req_ready), 64'd0);
        @(negedge clk); // precharge 2
        junk_inputs();
        chk(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
        chk(row_stb_n == 2'b11 && col_stb_n == 1'b1 && req_ready == 1'b0, "R9 precharge length",
            64'({row_stb_n, col_stb_n, req_ready}), 64'b1110);
        chk(rd_data == last_rd, "R7 read data held", 64'(rd_data), 64'(last_rd));
        req_valid = 1'b0;
        @(negedge clk); // idle again
        chk(req_ready == 1'b1 && row_stb_n == 2'b11, "R9 ready after precharge",
            64'({req_ready, row_stb_n}), 64'b111);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && row_stb_n == 2'b11 && col_stb_n == 1'b1 &&
            mem_wr_en == 1'b0 && done == 1'b0 && rd_data == '0, "R1 reset state",
            64'({req_ready, row_stb_n, col_stb_n, mem_wr_en, done}), 64'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle with no request stays idle
        @(negedge clk);
        chk(req_ready == 1'b1 && row_stb_n == 2'b11, "R10 idle without request",
            64'({req_ready, row_stb_n}), 64'b111);
        // directed corners
        access(23'h000000, 1'b0, 32'h0, 32'hA5A5_5A5A);
        access(23'h7FFFFF, 1'b1, 32'hDEAD_BEEF, 32'h1111_2222);
        access(23'h3FFFFF, 1'b1, 32'h1234_5678, 32'h0);
        access(23'h400000, 1'b0, 32'h0, 32'hFFFF_FFFF);
        access(23'h2AA555, 1'b1, 32'hCAFE_F00D, 32'h3333_4444);
        // random mix
        for (int i = 0; i < 60; i++) begin
            access(23'($urandom), 1'($urandom), $urandom, $urandom);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !finished) begin
                finished = 1'b1;
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end
endmodule